// File: doc/BRIEF.md
# External Interrupt Pending Controller

This block watches a bank of asynchronous interrupt lines (23 by default) and keeps one sticky pending flag per line. A flag is set when the edge chosen for that line arrives, or when software raises it through a per-line trigger bit. Software clears a flag by writing 1 to it. While a line is pending and unmasked, its request output is high.

Software reaches five 32-bit registers through a single-cycle write/read strobe bus. The registers are mask, rising select, falling select, software trigger and pending. Read data appears in the cycle after the read strobe. Each input line passes through two synchronizer flops and then an edge detector. As a result, an edge on a line is reflected in the pending flag after the third rising clock edge following the input change.

Top module: `irqp_ctrl`

## Requirements
- R1: After reset the mask, rising select, falling select, trigger and pending registers are all 0, and every request output is 0.
- R2: The mask (offset 0x00), rising select (0x08) and falling select (0x0C) registers read back the value written in bits 22:0. Bits 31:23 of every read return 0 and ignore writes.
- R3: A read of any address other than 0x00, 0x08, 0x0C, 0x10 or 0x14 returns 0 in the cycle after the read strobe.
- R4: A rising edge on a line whose rising select bit is 1 sets that line's pending bit (offset 0x14). The same holds for a falling edge with the falling select bit, and for either edge when both select bits are 1. The bit is set at the third clock edge after the input change. An edge of the unselected polarity sets nothing.
- R5: A line whose rising and falling select bits are both 0 never becomes pending from input activity.
- R6: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R7: Request output bit x equals pending bit x AND mask bit x.
- R8: Writing 1 to trigger bit x (offset 0x10) while that bit holds 0 sets pending bit x only if mask bit x is 1. The trigger bit itself becomes 1 and reads back as 1 either way.
- R9: Writing 1 to a trigger bit that already holds 1 does not set the pending bit.
- R10: A trigger bit is cleared only when 1 is written to the matching pending bit. Writing 0 to the trigger register leaves it unchanged.
- R11: If a selected edge is detected in the same cycle that the pending bit is cleared by a write of 1, the pending bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 32 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| lines_in | input | 23 | Asynchronous interrupt lines |
| irq_out | output | 23 | Per-line interrupt request |

## Verification
The assertions check the following on every cycle:
- a pending flag or trigger bit never drops unless the pending register is written;
- a flag never rises on a line with no edge selected, except through a trigger write;
- a trigger write raises no flag on a masked line;
- a clear never beats a simultaneous edge;
- reserved and unmapped read bits stay 0.

Only the bench's scenarios can show the following:
- the exact three-cycle latency from a line change to its flag, swept over every line and both polarities;
- readback of the configuration registers;
- the trigger's dependence on its previous value;
- the request output under various masks.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    localparam int DW = 32;
    localparam int AW = 32;

    localparam logic [AW-1:0] OFS_MASK = 32'h0000_0000;
    localparam logic [AW-1:0] OFS_RISE = 32'h0000_0008;
    localparam logic [AW-1:0] OFS_FALL = 32'h0000_000C;
    localparam logic [AW-1:0] OFS_SWT  = 32'h0000_0010;
    localparam logic [AW-1:0] OFS_PEND = 32'h0000_0014;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_RISE,
        SEL_FALL,
        SEL_SWT,
        SEL_PEND
    } reg_sel_e;

    typedef struct packed {
        logic          wr;
        logic          rd;
        reg_sel_e      sel;
        logic [DW-1:0] data;
    } bus_req_t;

    function automatic reg_sel_e decode_addr(input logic [AW-1:0] a);
        case (a)
            OFS_MASK: decode_addr = SEL_MASK;
            OFS_RISE: decode_addr = SEL_RISE;
            OFS_FALL: decode_addr = SEL_FALL;
            OFS_SWT:  decode_addr = SEL_SWT;
            OFS_PEND: decode_addr = SEL_PEND;
            default:  decode_addr = SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irqp_line_edge.sv
module irqp_line_edge (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic rise_en,
    input  logic fall_en,
    output logic hit
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        hit = (rise_en & sync_q & ~prev_q) | (fall_en & ~sync_q & prev_q);
    end

endmodule

// File: rtl/irqp_pend_bank.sv
module irqp_pend_bank #(
    parameter int N = 23
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] edge_hit,
    input  logic [N-1:0] mask,
    input  logic         swt_wr,
    input  logic         pend_wr,
    input  logic [N-1:0] wval,
    output logic [N-1:0] pend,
    output logic [N-1:0] swt
);

    logic [N-1:0] pend_q;
    logic [N-1:0] swt_q;
    logic [N-1:0] sw_hit;
    logic [N-1:0] clr;
    logic [N-1:0] swt_set;

    always_comb begin
        swt_set = swt_wr ? wval : '0;
        clr     = pend_wr ? wval : '0;
        sw_hit  = swt_set & ~swt_q & mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            swt_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~clr) | edge_hit | sw_hit;
            swt_q  <= (swt_q | swt_set) & ~clr;
        end
    end

    assign pend = pend_q;
    assign swt  = swt_q;

    // R6: a pending bit only falls when the pending register is written
    a_r6_pend_sticky: assert property (@(posedge clk) disable iff (rst)
        !pend_wr |=> ((~pend_q & $past(pend_q)) == '0));

    // R10: a trigger bit only falls on a pending-register write
    a_r10_swt_sticky: assert property (@(posedge clk) disable iff (rst)
        !pend_wr |=> ((~swt_q & $past(swt_q)) == '0));

    // R11: an edge coinciding with a clear leaves the bit set
    a_r11_edge_beats_clear: assert property (@(posedge clk) disable iff (rst)
        pend_wr |=> (($past(edge_hit) & ~pend_q) == '0));

endmodule

// File: rtl/irqp_ctrl.sv
module irqp_ctrl #(
    parameter int NUM_LINES = 23
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [31:0]          addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    input  logic [NUM_LINES-1:0] lines_in,
    output logic [NUM_LINES-1:0] irq_out
);
    import irqp_pkg::*;

    localparam int PADW = DW - NUM_LINES;

    bus_req_t             req;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] rise_q;
    logic [NUM_LINES-1:0] fall_q;
    logic [NUM_LINES-1:0] edge_hit;
    logic [NUM_LINES-1:0] pend;
    logic [NUM_LINES-1:0] swt;
    logic [NUM_LINES-1:0] rd_mux;
    logic [NUM_LINES-1:0] wval;
    logic                 unused_hi;

    always_comb begin
        req.wr   = wr_en;
        req.rd   = rd_en;
        req.sel  = decode_addr(addr);
        req.data = wdata;
    end

    assign wval      = req.data[NUM_LINES-1:0];
    assign unused_hi = ^req.data[DW-1:NUM_LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else if (req.wr) begin
            case (req.sel)
                SEL_MASK: mask_q <= wval;
                SEL_RISE: rise_q <= wval;
                SEL_FALL: fall_q <= wval;
                default:  ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irqp_line_edge u_edge (
            .clk     (clk),
            .rst     (rst),
            .din     (lines_in[g]),
            .rise_en (rise_q[g]),
            .fall_en (fall_q[g]),
            .hit     (edge_hit[g])
        );
    end

    irqp_pend_bank #(.N(NUM_LINES)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .edge_hit (edge_hit),
        .mask     (mask_q),
        .swt_wr   (req.wr && req.sel == SEL_SWT),
        .pend_wr  (req.wr && req.sel == SEL_PEND),
        .wval     (wval),
        .pend     (pend),
        .swt      (swt)
    );

    always_comb begin
        case (req.sel)
            SEL_MASK: rd_mux = mask_q;
            SEL_RISE: rd_mux = rise_q;
            SEL_FALL: rd_mux = fall_q;
            SEL_SWT:  rd_mux = swt;
            SEL_PEND: rd_mux = pend;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (req.rd) rdata <= {{PADW{1'b0}}, rd_mux};
        else             rdata <= '0;
    end

    assign irq_out = pend & mask_q;

    // R2: reserved read bits are always zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        rdata[DW-1:NUM_LINES] == '0);

    // R3: unmapped read returns zero next cycle
    a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.sel == SEL_NONE) |=> (rdata == '0));

    // R5: no selected edge and no trigger write means no new pending bits
    a_r5_no_select_quiet: assert property (@(posedge clk) disable iff (rst)
        (!(req.wr && req.sel == SEL_SWT) && ((rise_q | fall_q) == '0))
        |=> ((pend & ~$past(pend)) == '0));

    // R8: a trigger write raises no bit on a masked line without an edge
    a_r8_masked_trigger: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_SWT)
        |=> ((pend & ~$past(pend) & ~$past(mask_q) & ~$past(edge_hit)) == '0));

endmodule

// File: tb/irqp_ctrl_test.sv
`timescale 1ns/1ps
module irqp_ctrl_test;

    localparam int NL = 23;
    localparam logic [31:0] ALL = 32'h007F_FFFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [31:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NL-1:0] lines = '0;
    logic [NL-1:0] irq_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irqp_ctrl #(.NUM_LINES(NL)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .lines_in(lines), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic drive_lines(input logic [NL-1:0] v);
        @(negedge clk);
        lines = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_reg(input string req, input logic [31:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 irq", {9'd0, irq_out}, 32'd0);
        expect_reg("R1 mask", 32'h00, 32'd0);
        expect_reg("R1 rise", 32'h08, 32'd0);
        expect_reg("R1 fall", 32'h0C, 32'd0);
        expect_reg("R1 swt",  32'h10, 32'd0);
        expect_reg("R1 pend", 32'h14, 32'd0);

        // R2: readback with reserved bits dropped
        wr(32'h00, 32'hFFFF_FFFF);
        wr(32'h08, 32'hA5A5_A5A5);
        wr(32'h0C, 32'h5A5A_5A5A);
        expect_reg("R2 mask", 32'h00, ALL);
        expect_reg("R2 rise", 32'h08, 32'hA5A5_A5A5 & ALL);
        expect_reg("R2 fall", 32'h0C, 32'h5A5A_5A5A & ALL);

        // R3: unmapped offsets read as zero
        expect_reg("R3 0x04", 32'h04, 32'd0);
        expect_reg("R3 0x18", 32'h18, 32'd0);
        expect_reg("R3 0x09", 32'h09, 32'd0);
        expect_reg("R3 hi",   32'h1000_0010, 32'd0);

        // R5: no edge selected
        wr(32'h08, 32'd0);
        wr(32'h0C, 32'd0);
        drive_lines('1);
        drive_lines('0);
        expect_reg("R5 pend", 32'h14, 32'd0);
        check("R5 irq", {9'd0, irq_out}, 32'd0);

        // R4: rising sweep over every line
        wr(32'h08, ALL);
        for (int i = 0; i < NL; i++) begin
            drive_lines(lines | (NL'(1) << i));
            check($sformatf("R4 rise irq line %0d", i), {9'd0, irq_out}, 32'd1 << i);
            expect_reg("R4 rise pend", 32'h14, 32'd1 << i);
            wr(32'h14, 32'd1 << i);
            expect_reg("R6 clear", 32'h14, 32'd0);
        end
        drive_lines('0);
        expect_reg("R4 falling ignored", 32'h14, 32'd0);

        // R4: falling sweep
        wr(32'h08, 32'd0);
        wr(32'h0C, ALL);
        drive_lines('1);
        expect_reg("R4 rising ignored", 32'h14, 32'd0);
        for (int i = 0; i < NL; i++) begin
            drive_lines(lines & ~(NL'(1) << i));
            check($sformatf("R4 fall irq line %0d", i), {9'd0, irq_out}, 32'd1 << i);
            wr(32'h14, 32'd1 << i);
        end
        expect_reg("R4 fall cleared", 32'h14, 32'd0);

        // R4: both polarities on one line
        wr(32'h08, 32'h8);
        wr(32'h0C, 32'h8);
        drive_lines(NL'(8));
        expect_reg("R4 both up", 32'h14, 32'h8);
        wr(32'h14, 32'h8);
        drive_lines('0);
        expect_reg("R4 both down", 32'h14, 32'h8);

        // R6: writing zeros leaves the bit
        wr(32'h14, 32'd0);
        expect_reg("R6 write0", 32'h14, 32'h8);
        wr(32'h14, ALL & ~32'h8);
        expect_reg("R6 other bits", 32'h14, 32'h8);
        wr(32'h14, 32'h8);
        expect_reg("R6 cleared", 32'h14, 32'd0);

        // R7: request is pending AND mask
        wr(32'h08, ALL);
        wr(32'h0C, 32'd0);
        drive_lines('1);
        expect_reg("R7 pend all", 32'h14, ALL);
        begin
            logic [31:0] masks [4];
            masks[0] = 32'h0000_0000;
            masks[1] = 32'h0000_ABCD;
            masks[2] = 32'h0055_0F0F;
            masks[3] = ALL;
            for (int k = 0; k < 4; k++) begin
                wr(32'h00, masks[k]);
                @(negedge clk);
                check($sformatf("R7 mask %0d", k), {9'd0, irq_out}, masks[k] & ALL);
            end
        end
        wr(32'h14, ALL);
        wr(32'h08, 32'd0);
        drive_lines('0);
        expect_reg("R7 cleared", 32'h14, 32'd0);

        // R8: trigger on masked vs unmasked lines
        wr(32'h00, 32'h0F);
        wr(32'h10, 32'h33);
        expect_reg("R8 pend", 32'h14, 32'h03);
        expect_reg("R8 swt", 32'h10, 32'h33);
        check("R8 irq", {9'd0, irq_out}, 32'h03);

        // R10: zero write does not clear trigger; pending clear does
        wr(32'h10, 32'd0);
        expect_reg("R10 swt kept", 32'h10, 32'h33);
        wr(32'h14, 32'h03);
        expect_reg("R10 swt after clr", 32'h10, 32'h30);
        expect_reg("R10 pend after clr", 32'h14, 32'd0);

        // R9: trigger already 1 does nothing
        wr(32'h00, ALL);
        wr(32'h10, 32'h30);
        expect_reg("R9 no retrigger", 32'h14, 32'd0);
        wr(32'h14, 32'h30);
        expect_reg("R9 swt cleared", 32'h10, 32'd0);
        wr(32'h10, 32'h30);
        expect_reg("R9 fresh trigger", 32'h14, 32'h30);
        wr(32'h14, 32'h30);

        // R11: edge coincides with clear
        wr(32'h08, 32'h80);
        wr(32'h0C, 32'h80);
        drive_lines(NL'(32'h80));
        expect_reg("R11 setup", 32'h14, 32'h80);
        @(negedge clk);
        lines = '0;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; addr = 32'h14; wdata = 32'h80;
        @(negedge clk);
        wr_en = 1'b0;
        expect_reg("R11 edge wins", 32'h14, 32'h80);
        wr(32'h14, 32'h80);
        expect_reg("R11 later clear", 32'h14, 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule